// File: doc/BRIEF.md
# NTB Configuration Command Engine

This block is the control side of a non-transparent bridge between two hosts. Each host owns a bank of 32-bit words that it reads and writes over a simple single-cycle register bus. A host first stages parameters (argument, a 64-bit address, a size) and then drops a command code into a mailbox word. One cycle later the engine checks the command, latches the translation parameters for a downstream address translator, clears the mailbox and posts a verdict in the status word.

Three commands exist: set up doorbells (count and interrupt flavour), set up a memory window (target address, length, window index), and link up. Link-up requests from the two host ports are collected, and once both hosts have asked, a single link-up event pulse is sent to both of them. The bank also holds one data word per doorbell, which the translator looks up by doorbell number, plus a handful of read-only constants describing the layout.

Top module: `ntb_cfg_engine`

## Requirements
- R1: After a synchronous reset every writable word, the status word, all translation outputs and both link events read 0.
- R2: Word addresses: command 0, argument 1, status 2, topology 3, address low 4, address high 5, size 6, doorbell data at 12 + n for doorbell n (n from 0 to NUM_DB-1); the writable words read back the last value written and any address past the doorbell data reads 0.
- R3: Words 7 to 11 read as constants (window count 4, window-1 offset 0x1000, scratchpad offset 0x100, scratchpad count 16, doorbell entry size 4 by default) and writes to them, to status and to topology are ignored; topology reads 1 on port 0 and 2 on port 1.
- R4: A nonzero command write is visible in the command word and sets status to 0 at the writing edge; at the next edge the command word returns to 0 and status becomes 1 (accepted) or 2 (rejected). Writing 0 to the command word has no effect.
- R5: Command 1 with argument bits [15:0] at most NUM_DB (32) is accepted and sets the doorbell count output to those bits and the MSI-X select output to argument bit 16.
- R6: Command 1 with a count above NUM_DB is rejected and leaves the doorbell outputs unchanged.
- R7: Command 2 with an argument below the window count is accepted and sets the window base output to {address high, address low}, the window size output to size and the window index output to the argument.
- R8: Command 2 with an argument at or above the window count is rejected and leaves the window outputs unchanged.
- R9: Any other nonzero command code is rejected with status 2.
- R10: Command 3 is accepted; the link event outputs of both ports pulse high for exactly one cycle, in the second cycle after the later of the two ports' link-up commands is accepted, and never while only one port has asked.
- R11: The link event fires once; further link-up commands from either port until reset raise no event.
- R12: The doorbell data output of each port returns the stored data word of the doorbell number on that port's select input, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 2 | Per-port write strobe |
| host_addr | input | 2 x ADDR_W | Per-port word address |
| host_wdata | input | 2 x 32 | Per-port write data |
| host_rdata | output | 2 x 32 | Per-port read data for host_addr, combinational |
| bell_sel | input | 2 x DB_IDX_W | Doorbell number looked up by the translator |
| bell_data | output | 2 x 32 | Data word of the selected doorbell |
| win_base | output | 2 x 64 | Latched window target address |
| win_size | output | 2 x 32 | Latched window length |
| win_index | output | 2 x MW_IDX_W | Latched window index |
| bell_count | output | 2 x 16 | Latched number of doorbells |
| bell_msix | output | 2 | Latched MSI-X select |
| link_event | output | 2 | Link-up event pulse to each host |

## Verification
Each command is driven with an accepted argument and with the argument just past its limit (doorbell counts 8, 32 and 33; window indices 3 and 4), which separates an off-by-one in the range checks from a missing latch enable. The link-up handshake is tried with a single port, with both ports, and with a repeat after pairing, and the event is sampled cycle by cycle to pin its exact position and width. Writes to read-only words and a zero command write show that the bank ignores them, and the second port is read after the first port's commands to show that the two banks stay independent.

// File: rtl/ntb_cfg_pkg.sv
`timescale 1ns/1ps
package ntb_cfg_pkg;

    localparam int WORD_W = 32;

    // word offsets inside a host's bank (decoded by host software)
    localparam int FLD_CMD      = 0;
    localparam int FLD_ARG      = 1;
    localparam int FLD_STATUS   = 2;
    localparam int FLD_TOPO     = 3;
    localparam int FLD_ADDR_LO  = 4;
    localparam int FLD_ADDR_HI  = 5;
    localparam int FLD_SIZE     = 6;
    localparam int FLD_WIN_CNT  = 7;
    localparam int FLD_WIN1_OFS = 8;
    localparam int FLD_SPAD_OFS = 9;
    localparam int FLD_SPAD_CNT = 10;
    localparam int FLD_BELL_ESZ = 11;
    localparam int FLD_BELL_BASE = 12;

    // command codes
    localparam logic [WORD_W-1:0] CMD_NONE = 32'd0;
    localparam logic [WORD_W-1:0] CMD_BELL = 32'd1;
    localparam logic [WORD_W-1:0] CMD_WIN  = 32'd2;
    localparam logic [WORD_W-1:0] CMD_LINK = 32'd3;

    // topology codes
    localparam logic [WORD_W-1:0] TOPO_UP_B2B   = 32'd1;
    localparam logic [WORD_W-1:0] TOPO_DOWN_B2B = 32'd2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DONE   = 2'd1,
        ST_REJECT = 2'd2
    } cmd_status_e;

    typedef struct packed {
        logic [63:0]       base;
        logic [WORD_W-1:0] size;
    } win_cfg_t;

    typedef struct packed {
        logic [15:0] count;
        logic        msix;
    } bell_cfg_t;

    typedef struct packed {
        logic accept;
        logic reject;
        logic is_bell;
        logic is_win;
        logic is_link;
    } cmd_verdict_t;

    function automatic logic [WORD_W-1:0] topo_code(input int port);
        return (port == 0) ? TOPO_UP_B2B : TOPO_DOWN_B2B;
    endfunction

endpackage

// File: rtl/ntb_cmd_exec.sv
`timescale 1ns/1ps
module ntb_cmd_exec
    import ntb_cfg_pkg::*;
#(
    parameter int NUM_DB   = 32,
    parameter int MW_COUNT = 4
) (
    input  logic [WORD_W-1:0] cmd_i,
    input  logic [WORD_W-1:0] arg_i,
    output cmd_verdict_t      verdict_o
);

    logic bell_ok;
    logic win_ok;

    assign bell_ok = int'(arg_i[15:0]) <= NUM_DB;
    assign win_ok  = arg_i < 32'(MW_COUNT);

    always_comb begin
        verdict_o = '0;
        case (cmd_i)
            CMD_NONE: ;
            CMD_BELL: begin
                verdict_o.is_bell = 1'b1;
                verdict_o.accept  = bell_ok;
                verdict_o.reject  = !bell_ok;
            end
            CMD_WIN: begin
                verdict_o.is_win = 1'b1;
                verdict_o.accept = win_ok;
                verdict_o.reject = !win_ok;
            end
            CMD_LINK: begin
                verdict_o.is_link = 1'b1;
                verdict_o.accept  = 1'b1;
            end
            default: verdict_o.reject = 1'b1;
        endcase
    end

endmodule

// File: rtl/ntb_bell_table.sv
`timescale 1ns/1ps
module ntb_bell_table
    import ntb_cfg_pkg::*;
#(
    parameter int NUM_DB   = 32,
    parameter int DB_IDX_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [DB_IDX_W-1:0] wr_idx_i,
    input  logic [WORD_W-1:0]   wdata_i,
    input  logic [DB_IDX_W-1:0] host_idx_i,
    output logic [WORD_W-1:0]   host_data_o,
    input  logic [DB_IDX_W-1:0] sel_idx_i,
    output logic [WORD_W-1:0]   sel_data_o
);

    logic [WORD_W-1:0] words [NUM_DB];

    for (genvar g = 0; g < NUM_DB; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (wr_en_i && wr_idx_i == DB_IDX_W'(g)) begin
                word_q <= wdata_i;
            end
        end
        assign words[g] = word_q;
    end

    assign host_data_o = words[host_idx_i];
    assign sel_data_o  = words[sel_idx_i];

endmodule

// File: rtl/ntb_link_pair.sv
`timescale 1ns/1ps
module ntb_link_pair (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req_i,
    output logic       event_o
);

    logic [1:0] seen_q;
    logic       fired_q;
    logic       event_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= '0;
            fired_q <= 1'b0;
            event_q <= 1'b0;
        end else begin
            seen_q  <= seen_q | req_i;
            event_q <= (&seen_q) && !fired_q;
            if (&seen_q) begin
                fired_q <= 1'b1;
            end
        end
    end

    assign event_o = event_q;

    AST_EVENT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        event_q |-> (&seen_q)) else $error("link event without both requests"); // R10
    AST_EVENT_ONCE: assert property (@(posedge clk) disable iff (rst)
        fired_q |=> !event_q) else $error("link event repeated"); // R11

endmodule

// File: rtl/ntb_cfg_region.sv
`timescale 1ns/1ps
module ntb_cfg_region
    import ntb_cfg_pkg::*;
#(
    parameter int                PORT_ID       = 0,
    parameter int                NUM_DB        = 32,
    parameter int                MW_COUNT      = 4,
    parameter logic [WORD_W-1:0] WIN1_OFFSET   = 32'h0000_1000,
    parameter logic [WORD_W-1:0] SPAD_OFFSET   = 32'h0000_0100,
    parameter logic [WORD_W-1:0] SPAD_COUNT    = 32'd16,
    parameter logic [WORD_W-1:0] BELL_ENTRY_SZ = 32'd4,
    parameter int                ADDR_W        = 6,
    parameter int                MW_IDX_W      = 2,
    parameter int                DB_IDX_W      = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [WORD_W-1:0]   rdata_o,
    input  logic [DB_IDX_W-1:0] bell_sel_i,
    output logic [WORD_W-1:0]   bell_data_o,
    output win_cfg_t            win_o,
    output logic [MW_IDX_W-1:0] win_idx_o,
    output bell_cfg_t           bell_o,
    output logic                link_req_o
);

    localparam logic [WORD_W-1:0] TOPO = topo_code(PORT_ID);

    logic [WORD_W-1:0]   cmd_q;
    logic [WORD_W-1:0]   arg_q;
    logic [WORD_W-1:0]   addr_lo_q;
    logic [WORD_W-1:0]   addr_hi_q;
    logic [WORD_W-1:0]   size_q;
    cmd_status_e         status_q;
    win_cfg_t            win_q;
    logic [MW_IDX_W-1:0] win_idx_q;
    bell_cfg_t           bell_q;
    cmd_verdict_t        verdict;

    logic                in_bell;
    logic [ADDR_W-1:0]   bell_off;
    logic [DB_IDX_W-1:0] bell_idx;
    logic [WORD_W-1:0]   bell_host_word;
    logic                cmd_wr;

    assign in_bell  = (int'(addr_i) >= FLD_BELL_BASE) && (int'(addr_i) < FLD_BELL_BASE + NUM_DB);
    assign bell_off = addr_i - ADDR_W'(FLD_BELL_BASE);
    assign bell_idx = bell_off[DB_IDX_W-1:0];
    assign cmd_wr   = wr_en_i && addr_i == ADDR_W'(FLD_CMD) && wdata_i != CMD_NONE;

    ntb_cmd_exec #(
        .NUM_DB   (NUM_DB),
        .MW_COUNT (MW_COUNT)
    ) u_exec (
        .cmd_i     (cmd_q),
        .arg_i     (arg_q),
        .verdict_o (verdict)
    );

    ntb_bell_table #(
        .NUM_DB   (NUM_DB),
        .DB_IDX_W (DB_IDX_W)
    ) u_bells (
        .clk         (clk),
        .rst         (rst),
        .wr_en_i     (wr_en_i && in_bell),
        .wr_idx_i    (bell_idx),
        .wdata_i     (wdata_i),
        .host_idx_i  (bell_idx),
        .host_data_o (bell_host_word),
        .sel_idx_i   (bell_sel_i),
        .sel_data_o  (bell_data_o)
    );

    // mailbox processing and host writes
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            arg_q     <= '0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
            size_q    <= '0;
            status_q  <= ST_IDLE;
            win_q     <= '0;
            win_idx_q <= '0;
            bell_q    <= '0;
        end else begin
            if (cmd_q != CMD_NONE) begin
                cmd_q <= CMD_NONE;
                if (verdict.accept) begin
                    status_q <= ST_DONE;
                end else if (verdict.reject) begin
                    status_q <= ST_REJECT;
                end
                if (verdict.accept && verdict.is_bell) begin
                    bell_q.count <= arg_q[15:0];
                    bell_q.msix  <= arg_q[16];
                end
                if (verdict.accept && verdict.is_win) begin
                    win_q.base <= {addr_hi_q, addr_lo_q};
                    win_q.size <= size_q;
                    win_idx_q  <= arg_q[MW_IDX_W-1:0];
                end
            end
            if (cmd_wr) begin
                cmd_q    <= wdata_i;
                status_q <= ST_IDLE;
            end
            if (wr_en_i) begin
                case (int'(addr_i))
                    FLD_ARG:     arg_q     <= wdata_i;
                    FLD_ADDR_LO: addr_lo_q <= wdata_i;
                    FLD_ADDR_HI: addr_hi_q <= wdata_i;
                    FLD_SIZE:    size_q    <= wdata_i;
                    default: ;
                endcase
            end
        end
    end

    // host read path
    always_comb begin
        rdata_o = '0;
        if (in_bell) begin
            rdata_o = bell_host_word;
        end else begin
            case (int'(addr_i))
                FLD_CMD:      rdata_o = cmd_q;
                FLD_ARG:      rdata_o = arg_q;
                FLD_STATUS:   rdata_o = 32'(status_q);
                FLD_TOPO:     rdata_o = TOPO;
                FLD_ADDR_LO:  rdata_o = addr_lo_q;
                FLD_ADDR_HI:  rdata_o = addr_hi_q;
                FLD_SIZE:     rdata_o = size_q;
                FLD_WIN_CNT:  rdata_o = 32'(MW_COUNT);
                FLD_WIN1_OFS: rdata_o = WIN1_OFFSET;
                FLD_SPAD_OFS: rdata_o = SPAD_OFFSET;
                FLD_SPAD_CNT: rdata_o = SPAD_COUNT;
                FLD_BELL_ESZ: rdata_o = BELL_ENTRY_SZ;
                default:      rdata_o = '0;
            endcase
        end
    end

    assign win_o      = win_q;
    assign win_idx_o  = win_idx_q;
    assign bell_o     = bell_q;
    assign link_req_o = verdict.accept && verdict.is_link;

    AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != CMD_NONE && !cmd_wr) |=> (cmd_q == CMD_NONE)) else $error("mailbox not cleared"); // R4
    AST_STATUS_POSTED: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != CMD_NONE && !cmd_wr) |=> (status_q != ST_IDLE)) else $error("no verdict posted"); // R4
    AST_BELL_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        int'(bell_q.count) <= NUM_DB) else $error("doorbell count above limit"); // R6
    AST_WIN_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_WIN && arg_q >= 32'(MW_COUNT)) |=> ($stable(win_q) && $stable(win_idx_q)))
        else $error("rejected window changed outputs"); // R8

endmodule

// File: rtl/ntb_cfg_engine.sv
`timescale 1ns/1ps
module ntb_cfg_engine
    import ntb_cfg_pkg::*;
#(
    parameter int                NUM_DB        = 32,
    parameter int                MW_COUNT      = 4,
    parameter logic [WORD_W-1:0] WIN1_OFFSET   = 32'h0000_1000,
    parameter logic [WORD_W-1:0] SPAD_OFFSET   = 32'h0000_0100,
    parameter logic [WORD_W-1:0] SPAD_COUNT    = 32'd16,
    parameter logic [WORD_W-1:0] BELL_ENTRY_SZ = 32'd4,
    localparam int ADDR_W   = $clog2(FLD_BELL_BASE + NUM_DB),
    localparam int MW_IDX_W = (MW_COUNT > 1) ? $clog2(MW_COUNT) : 1,
    localparam int DB_IDX_W = (NUM_DB > 1) ? $clog2(NUM_DB) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               host_wr_en,
    input  logic [1:0][ADDR_W-1:0]   host_addr,
    input  logic [1:0][WORD_W-1:0]   host_wdata,
    output logic [1:0][WORD_W-1:0]   host_rdata,
    input  logic [1:0][DB_IDX_W-1:0] bell_sel,
    output logic [1:0][WORD_W-1:0]   bell_data,
    output logic [1:0][63:0]         win_base,
    output logic [1:0][WORD_W-1:0]   win_size,
    output logic [1:0][MW_IDX_W-1:0] win_index,
    output logic [1:0][15:0]         bell_count,
    output logic [1:0]               bell_msix,
    output logic [1:0]               link_event
);

    localparam int NUM_HOSTS = 2;

    logic [NUM_HOSTS-1:0] link_req;
    logic                 pair_event;

    for (genvar h = 0; h < NUM_HOSTS; h++) begin : g_host
        win_cfg_t  win_cfg;
        bell_cfg_t bell_cfg;

        ntb_cfg_region #(
            .PORT_ID       (h),
            .NUM_DB        (NUM_DB),
            .MW_COUNT      (MW_COUNT),
            .WIN1_OFFSET   (WIN1_OFFSET),
            .SPAD_OFFSET   (SPAD_OFFSET),
            .SPAD_COUNT    (SPAD_COUNT),
            .BELL_ENTRY_SZ (BELL_ENTRY_SZ),
            .ADDR_W        (ADDR_W),
            .MW_IDX_W      (MW_IDX_W),
            .DB_IDX_W      (DB_IDX_W)
        ) u_region (
            .clk         (clk),
            .rst         (rst),
            .wr_en_i     (host_wr_en[h]),
            .addr_i      (host_addr[h]),
            .wdata_i     (host_wdata[h]),
            .rdata_o     (host_rdata[h]),
            .bell_sel_i  (bell_sel[h]),
            .bell_data_o (bell_data[h]),
            .win_o       (win_cfg),
            .win_idx_o   (win_index[h]),
            .bell_o      (bell_cfg),
            .link_req_o  (link_req[h])
        );

        assign win_base[h]   = win_cfg.base;
        assign win_size[h]   = win_cfg.size;
        assign bell_count[h] = bell_cfg.count;
        assign bell_msix[h]  = bell_cfg.msix;
        assign link_event[h] = pair_event;
    end

    ntb_link_pair u_pair (
        .clk     (clk),
        .rst     (rst),
        .req_i   (link_req),
        .event_o (pair_event)
    );

endmodule

// File: tb/ntb_cfg_engine_bench.sv
`timescale 1ns/1ps
module ntb_cfg_engine_bench;

    localparam int ADDR_W = 6;
    localparam int IDX_W  = 5;

    localparam int K_RD    = 0;
    localparam int K_BASE  = 1;
    localparam int K_SIZE  = 2;
    localparam int K_IDX   = 3;
    localparam int K_CNT   = 4;
    localparam int K_MSIX  = 5;
    localparam int K_BDATA = 6;
    localparam int K_EVT   = 7;

    typedef struct {
        int          kind;
        int          port;
        logic [63:0] exp;
        string       tag;
    } exp_item_t;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [1:0]            host_wr_en = '0;
    logic [1:0][ADDR_W-1:0] host_addr = '0;
    logic [1:0][31:0]      host_wdata = '0;
    logic [1:0][31:0]      host_rdata;
    logic [1:0][IDX_W-1:0] bell_sel = '0;
    logic [1:0][31:0]      bell_data;
    logic [1:0][63:0]      win_base;
    logic [1:0][31:0]      win_size;
    logic [1:0][1:0]       win_index;
    logic [1:0][15:0]      bell_count;
    logic [1:0]            bell_msix;
    logic [1:0]            link_event;

    exp_item_t q[$];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    ntb_cfg_engine u_ntb_cfg_engine (
        .clk        (clk),
        .rst        (rst),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .bell_sel   (bell_sel),
        .bell_data  (bell_data),
        .win_base   (win_base),
        .win_size   (win_size),
        .win_index  (win_index),
        .bell_count (bell_count),
        .bell_msix  (bell_msix),
        .link_event (link_event)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int p, input int a, input logic [31:0] d);
        host_wr_en[p] = 1'b1;
        host_addr[p]  = ADDR_W'(a);
        host_wdata[p] = d;
        tick();
        host_wr_en[p] = 1'b0;
    endtask

    // driver: queues an expectation checked at the next falling edge
    task automatic chk(input int kind, input int p, input int a, input logic [63:0] e, input string tag);
        exp_item_t it;
        if (kind == K_RD) host_addr[p] = ADDR_W'(a);
        if (kind == K_BDATA) bell_sel[p] = IDX_W'(a);
        it.kind = kind;
        it.port = p;
        it.exp  = e;
        it.tag  = tag;
        q.push_back(it);
    endtask

    // monitor
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_item_t it;
            logic [63:0] act;
            it = q.pop_front();
            case (it.kind)
                K_RD:    act = 64'(host_rdata[it.port]);
                K_BASE:  act = win_base[it.port];
                K_SIZE:  act = 64'(win_size[it.port]);
                K_IDX:   act = 64'(win_index[it.port]);
                K_CNT:   act = 64'(bell_count[it.port]);
                K_MSIX:  act = 64'(bell_msix[it.port]);
                K_BDATA: act = 64'(bell_data[it.port]);
                default: act = 64'(link_event[it.port]);
            endcase
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s port %0d kind %0d: actual %h expected %h", it.tag, it.port, it.kind, act, it.exp);
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk(K_RD, 0, 2, 0, "R1"); chk(K_RD, 1, 0, 0, "R1");
        chk(K_BASE, 0, 0, 0, "R1"); chk(K_CNT, 1, 0, 0, "R1");
        chk(K_EVT, 0, 0, 0, "R1"); chk(K_EVT, 1, 0, 0, "R1");
        tick();
        chk(K_RD, 0, 1, 0, "R1"); chk(K_RD, 1, 12, 0, "R1");
        tick();

        // R3 constants and topology
        chk(K_RD, 0, 3, 1, "R3"); chk(K_RD, 1, 3, 2, "R3"); tick();
        chk(K_RD, 0, 7, 4, "R3"); chk(K_RD, 1, 8, 64'h1000, "R3"); tick();
        chk(K_RD, 0, 9, 64'h100, "R3"); chk(K_RD, 1, 10, 16, "R3"); tick();
        chk(K_RD, 0, 11, 4, "R3"); tick();
        wr(0, 7, 32'hFFFF_FFFF);
        wr(0, 3, 32'h55);
        wr(0, 2, 32'h2);
        chk(K_RD, 0, 7, 4, "R3"); chk(K_RD, 1, 7, 4, "R3"); tick();
        chk(K_RD, 0, 3, 1, "R3"); tick();
        chk(K_RD, 0, 2, 0, "R3"); tick();

        // R2 readback and map
        wr(0, 1, 32'h1234_5678);
        wr(0, 5, 32'hCAFE_0001);
        chk(K_RD, 0, 1, 64'h1234_5678, "R2"); tick();
        chk(K_RD, 0, 5, 64'hCAFE_0001, "R2"); chk(K_RD, 1, 5, 0, "R2"); tick();
        chk(K_RD, 0, 50, 0, "R2"); tick();

        // R12 doorbell data words
        wr(0, 12, 32'hA0A0_0001);
        wr(0, 43, 32'hB1B1_0031);
        chk(K_RD, 0, 12, 64'hA0A0_0001, "R12"); chk(K_BDATA, 0, 31, 64'hB1B1_0031, "R12"); tick();
        chk(K_RD, 0, 43, 64'hB1B1_0031, "R12"); chk(K_BDATA, 0, 0, 64'hA0A0_0001, "R12");
        chk(K_BDATA, 1, 31, 0, "R12"); tick();

        // R5 doorbell accepted, with R4 timing
        wr(0, 1, 32'h0001_0008);
        wr(0, 0, 32'd1);
        chk(K_RD, 0, 0, 1, "R4"); tick();
        chk(K_RD, 0, 0, 0, "R4"); chk(K_CNT, 0, 0, 8, "R5"); chk(K_MSIX, 0, 0, 1, "R5"); tick();
        chk(K_RD, 0, 2, 1, "R4"); tick();
        wr(0, 1, 32'd32);
        wr(0, 0, 32'd1);
        chk(K_RD, 0, 2, 0, "R4"); tick();
        chk(K_RD, 0, 2, 1, "R5"); chk(K_CNT, 0, 0, 32, "R5"); chk(K_MSIX, 0, 0, 0, "R5"); tick();

        // R6 doorbell rejected
        wr(0, 1, 32'h0001_0021);
        wr(0, 0, 32'd1);
        tick();
        chk(K_RD, 0, 2, 2, "R6"); chk(K_CNT, 0, 0, 32, "R6"); chk(K_MSIX, 0, 0, 0, "R6"); tick();

        // R7 window accepted
        wr(0, 4, 32'hDEAD_0000);
        wr(0, 5, 32'h0000_0012);
        wr(0, 6, 32'h0001_0000);
        wr(0, 1, 32'd3);
        wr(0, 0, 32'd2);
        tick();
        chk(K_RD, 0, 2, 1, "R7"); chk(K_BASE, 0, 0, 64'h0000_0012_DEAD_0000, "R7");
        chk(K_SIZE, 0, 0, 64'h1_0000, "R7"); chk(K_IDX, 0, 0, 3, "R7"); chk(K_BASE, 1, 0, 0, "R7"); tick();

        // R8 window rejected
        wr(0, 4, 32'h0BAD_0000);
        wr(0, 1, 32'd4);
        wr(0, 0, 32'd2);
        tick();
        chk(K_RD, 0, 2, 2, "R8"); chk(K_BASE, 0, 0, 64'h0000_0012_DEAD_0000, "R8"); chk(K_IDX, 0, 0, 3, "R8"); tick();

        // R9 unknown code, then R4 zero write ignored
        wr(1, 0, 32'd7);
        tick();
        chk(K_RD, 1, 2, 2, "R9"); tick();
        wr(0, 1, 32'd1);
        wr(0, 0, 32'd2);
        tick();
        chk(K_RD, 0, 2, 1, "R7"); chk(K_IDX, 0, 0, 1, "R7"); tick();
        wr(0, 0, 32'd0);
        chk(K_RD, 0, 2, 1, "R4"); tick();
        chk(K_RD, 0, 0, 0, "R4"); tick();

        // R10 link pairing
        wr(0, 0, 32'd3);
        tick();
        chk(K_RD, 0, 2, 1, "R10"); chk(K_EVT, 0, 0, 0, "R10"); chk(K_EVT, 1, 0, 0, "R10"); tick();
        repeat (4) begin
            chk(K_EVT, 0, 0, 0, "R10"); chk(K_EVT, 1, 0, 0, "R10"); tick();
        end
        wr(1, 0, 32'd3);
        chk(K_EVT, 0, 0, 0, "R10"); chk(K_EVT, 1, 0, 0, "R10"); tick();
        chk(K_RD, 1, 2, 1, "R10"); chk(K_EVT, 0, 0, 0, "R10"); chk(K_EVT, 1, 0, 0, "R10"); tick();
        chk(K_EVT, 0, 0, 1, "R10"); chk(K_EVT, 1, 0, 1, "R10"); tick();
        chk(K_EVT, 0, 0, 0, "R10"); chk(K_EVT, 1, 0, 0, "R10"); tick();

        // R11 no second event
        wr(0, 0, 32'd3);
        wr(1, 0, 32'd3);
        repeat (5) begin
            chk(K_EVT, 0, 0, 0, "R11"); chk(K_EVT, 1, 0, 0, "R11"); tick();
        end
        chk(K_RD, 1, 2, 1, "R11"); tick();

        tick();
        tick();
        done = 1;
        report();
        $finish;
    end

endmodule